// File: doc/BRIEF.md
# Inter-Layer Result Selector with Rectifier and Pass Starter

This block sits between two layers of a serial neural-network datapath. It receives the wide accumulator results of every neuron in the preceding layer at once. Each cycle it picks one of them, using the weight-address count of the first neuron in the following layer as the index. The picked result is cut down to the narrow input format of the following layer by a fixed bit slice that drops the extra fractional and the extra integer bits. A rectifier then forces any value whose slice is negative to zero. An instance that feeds the network's final outputs is built with the rectifier removed, so raw values pass through.

The block also starts the following layer. The preceding layer raises a one-cycle completion pulse. The block delays that pulse by three cycles and then raises an enable for a configured number of cycles, one cycle per neuron of the preceding layer. The enable is the valid signal that walks the following layer through its serial pass. Once those cycles are done, the enable drops and the starter waits for the next pulse.

Top module: `layer_link`

## Requirements
- R1: `next_data` follows `src_data` and `sel_idx` in the same cycle. Slot i occupies bits [48*i+47 : 48*i] of `src_data`, and slot i is selected when `sel_idx` equals i.
- R2: With the default 12 fractional bits, the next-layer value is bits [38:12] of the selected 48-bit slot. Bits 11..0 and bits 47..39 are discarded with no rounding or saturation.
- R3: With the rectifier enabled (default), `next_data` is zero whenever bit 26 of the slice is 1. Otherwise `next_data` equals the slice. A zero slot gives zero.
- R4: A `sel_idx` value of N_SRC or more (12..15 by default) drives `next_data` to zero, whatever the slot contents.
- R5: With the rectifier disabled (output-layer instance), `next_data` equals the slice, including slices whose bit 26 is 1.
- R6: While `rst_n` is low, `next_en` is low.
- R7: If `done_pulse` is high at rising edge t while the starter is idle and `cfg_count` is nonzero, `next_en` goes high right after rising edge t+3.
- R8: Once raised, `next_en` stays high for exactly `cfg_count` consecutive cycles (the value held at the edge where it rises), then returns low.
- R9: A completion pulse whose delayed copy emerges while `next_en` is high is ignored. It neither extends nor restarts the pass.
- R10: A completion pulse that arrives when `cfg_count` is zero raises no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| src_data | input | N_SRC*48 | Accumulator results of the preceding layer, slot i in bits 48*i+47 .. 48*i |
| sel_idx | input | SEL_W (4) | Address count of the following layer's first neuron, used as slot index |
| done_pulse | input | 1 | One-cycle completion pulse from the preceding layer |
| cfg_count | input | CNT_W (5) | Number of enable cycles per pass (neurons in preceding layer) |
| next_data | output | 27 | Sliced and optionally rectified value for the following layer |
| next_en | output | 1 | Enable/valid that drives the following layer's serial pass |

## Verification
The selection path is tried with every slot holding a distinct value, so that a wrong index or a wrong slot offset shows up as a wrong value. Out-of-range indices are tried with all slots nonzero, so that only a forced zero passes. The slice is tried with values that have bits set only below bit 12, only at or above bit 39, at the slice sign bit 38, and all of bits 12..37. These separate a shifted slice, a missing discard and a wrong sign test. Positive, negative and zero values go through both the rectified instance and the raw instance, which shows that only the rectifier differs between them. The starter is tried with one normal pulse, a second pulse during a pass, a zero count, and a count of one. Each case is checked cycle by cycle, which separates a wrong delay, an off-by-one pass length, and a restart caused by a late pulse.

// File: rtl/layer_link.sv
module layer_link #(
  parameter int N_SRC     = 12,
  parameter int ACC_W     = 48,
  parameter int IN_W      = 27,
  parameter int FRAC_BITS = 12,
  parameter int SLICE_LO  = FRAC_BITS,
  parameter int SEL_W     = 4,
  parameter int CNT_W     = 5,
  parameter int DLY       = 3,
  parameter bit RELU_EN   = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC*ACC_W-1:0] src_data,
  input  logic [SEL_W-1:0]       sel_idx,
  input  logic                   done_pulse,
  input  logic [CNT_W-1:0]       cfg_count,
  output logic [IN_W-1:0]        next_data,
  output logic                   next_en
);

  localparam int SLICE_HI = SLICE_LO + IN_W - 1;

  // result selection
  logic [ACC_W-1:0] picked;
  logic [IN_W-1:0]  sliced;
  logic             unused_picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < N_SRC; i++)
      if (sel_idx == SEL_W'(i)) picked = src_data[i*ACC_W +: ACC_W];
  end

  assign sliced        = picked[SLICE_HI:SLICE_LO];
  assign unused_picked = ^{picked[ACC_W-1:SLICE_HI+1], picked[SLICE_LO-1:0]};

  generate
    if (RELU_EN) begin : g_relu
      assign next_data = sliced[IN_W-1] ? '0 : sliced;
    end else begin : g_raw
      assign next_data = sliced;
    end
  endgenerate

  // pass starter
  typedef enum logic {S_IDLE, S_RUN} st_t;
  st_t              st;
  logic [DLY-1:0]   dly;
  logic [CNT_W-1:0] rem;
  logic             kick;

  assign kick    = dly[DLY-1];
  assign next_en = (st == S_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) dly <= '0;
    else        dly <= DLY'({dly, done_pulse});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      rem <= '0;
    end else begin
      case (st)
        S_IDLE: if (kick && cfg_count != '0) begin
          st  <= S_RUN;
          rem <= cfg_count;
        end
        S_RUN: begin
          rem <= rem - 1'b1;
          if (rem == CNT_W'(1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // checking state
  logic [CNT_W-1:0] len_seen;
  logic [CNT_W-1:0] cfg_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_seen <= '0;
      cfg_hold <= '0;
    end else begin
      len_seen <= next_en ? len_seen + 1'b1 : '0;
      if (!next_en && kick) cfg_hold <= cfg_count;
    end
  end

  AST_UNUSED_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_idx) >= N_SRC) |-> (next_data == '0)); // R4

  AST_RECT_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    RELU_EN |-> !next_data[IN_W-1]); // R3

  AST_START_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !next_en && cfg_count != '0) |=> next_en); // R7

  AST_PASS_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(next_en) |-> (len_seen == cfg_hold)); // R8

  AST_ZERO_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !next_en && cfg_count == '0) |=> !next_en); // R10

endmodule

// File: tb/layer_link_test.sv
module layer_link_test;
  localparam int NS = 12;
  localparam int AW = 48;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS*AW-1:0] src_data = '0;
  logic [3:0]      sel_idx = '0;
  logic            done_pulse = 1'b0;
  logic [4:0]      cfg_count = '0;
  logic [26:0]     next_data, raw_data;
  logic            next_en, raw_en;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  layer_link uut (
    .clk(clk), .rst_n(rst_n), .src_data(src_data), .sel_idx(sel_idx),
    .done_pulse(done_pulse), .cfg_count(cfg_count),
    .next_data(next_data), .next_en(next_en));

  layer_link #(.RELU_EN(1'b0)) uut_raw (
    .clk(clk), .rst_n(rst_n), .src_data(src_data), .sel_idx(sel_idx),
    .done_pulse(1'b0), .cfg_count(cfg_count),
    .next_data(raw_data), .next_en(raw_en));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_slot(input int i, input logic [47:0] v);
    src_data[i*AW +: AW] = v;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R6 en during reset", {31'b0, next_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 en after reset", {31'b0, next_en}, 32'd0);
  endtask

  task automatic t_select;
    for (int i = 0; i < NS; i++) put_slot(i, 48'((i + 1) * 16 + 1) << 12);
    for (int i = 0; i < NS; i++) begin
      sel_idx = 4'(i);
      #1;
      check("R1 slot select", {5'b0, next_data}, 32'((i + 1) * 16 + 1));
    end
  endtask

  task automatic t_unused;
    for (int i = NS; i < 16; i++) begin
      sel_idx = 4'(i);
      #1;
      check("R4 unused index", {5'b0, next_data}, 32'd0);
      check("R4 unused index raw", {5'b0, raw_data}, 32'd0);
    end
  endtask

  task automatic slice_case(input string req, input logic [47:0] v,
                            input logic [26:0] exp_rect, input logic [26:0] exp_raw);
    put_slot(5, v);
    sel_idx = 4'd5;
    #1;
    check(req, {5'b0, next_data}, {5'b0, exp_rect});
    check({req, " raw R5"}, {5'b0, raw_data}, {5'b0, exp_raw});
  endtask

  task automatic t_slice;
    slice_case("R2 small", 48'h0000_0000_5000, 27'h5, 27'h5);
    slice_case("R2 drop frac", 48'h0000_0123_4FFF, 27'h1234, 27'h1234);
    slice_case("R2 below lsb", 48'h0000_0000_0FFF, 27'h0, 27'h0);
    slice_case("R2 drop top", 48'h0080_0000_3000, 27'h3, 27'h3);
    slice_case("R2 max positive", 48'h003F_FFFF_FFFF, 27'h3FF_FFFF, 27'h3FF_FFFF);
  endtask

  task automatic t_relu;
    slice_case("R3 sign bit only", 48'h0040_0000_0000, 27'h0, 27'h400_0000);
    slice_case("R3 minus one", 48'hFFFF_FFFF_FFFF, 27'h0, 27'h7FF_FFFF);
    slice_case("R3 negative", 48'hFFFF_FFFF_0000, 27'h0, 27'h7FF_FFF0);
    slice_case("R3 zero", 48'h0, 27'h0, 27'h0);
    slice_case("R3 positive", 48'h0000_0ABC_D000, 27'hABCD, 27'hABCD);
  endtask

  // pulse raised before edge t; sample k is taken after edge t+k-1
  task automatic run_pulse(input string req, input int cnt, input int second_at, input int span);
    cfg_count = 5'(cnt);
    @(negedge clk);
    done_pulse = 1'b1;
    for (int k = 1; k <= span; k++) begin
      @(negedge clk);
      done_pulse = (k == second_at);
      check(req, {31'b0, next_en}, {31'b0, (k >= 4 && k <= 3 + cnt)});
    end
    done_pulse = 1'b0;
  endtask

  task automatic t_start;
    run_pulse("R7 start delay", 5, 0, 4);
    repeat (8) @(negedge clk);
    check("R7 idle after pass", {31'b0, next_en}, 32'd0);
  endtask

  task automatic t_length;
    run_pulse("R8 pass length 7", 7, 0, 14);
    run_pulse("R8 pass length 1", 1, 0, 7);
    run_pulse("R8 pass length 31", 31, 0, 38);
  endtask

  task automatic t_busy;
    run_pulse("R9 late pulse ignored", 5, 2, 14);
  endtask

  task automatic t_zero;
    run_pulse("R10 zero count", 0, 0, 9);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_select;
    t_unused;
    t_slice;
    t_relu;
    t_start;
    t_length;
    t_busy;
    t_zero;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule